// File: doc/BRIEF.md
# SCL Phase Timer

This block paces the clock line of an I2C master. A bit engine hands it one bus operation at a time (a start condition, one data bit, a stop condition or a repeated start). The timer drives SCL low or lets it float for the programmed number of clock periods. It also sends the engine single-cycle strobes that say when to change SDA and when to sample it. Every phase length is a programmed count, and all of them are scaled by a shared prescaler. A fixed overhead of eight clocks plus an input-filter delay is inserted each time SCL is released. That delay, counted while the line reads high, is what lets a slave stretch the clock.

Two complete parameter sets are provided, one for fast speed and one for high speed. A mode input picks one set when each operation is accepted. The data-hold count and the filter count are shared by both sets. When SCL is not stretched, a data bit lasts (DIV+1)*(L+H+2)+8+F input clocks, where F is the filter count. With the `FLT_TWICE` variant F is replaced by 2F.

Top module: `scl_phase_timer`

## Requirements
- R1: After reset `scl_oe`, `sda_upd`, `smp` and `busy` are 0 and `cmd_ready` is 1.
- R2: A data bit (`cmd_op`=1) drives `scl_oe` from the clock after acceptance for (DIV+1)*(L+1) clocks when hold+setup does not exceed L. Each set vector holds seven 8-bit fields at bits [8k+7:8k]: k=0 SCL high, 1 SCL low, 2 data setup, 3 restart release, 4 stop setup, 5 start hold, 6 start setup. DIV has its own port.
- R3: During the low phase, `sda_upd` pulses once, HOLD*(DIV+1) clocks after SCL was pulled low.
- R4: When HOLD+SETUP exceeds L, the low phase lasts (DIV+1)*(HOLD+SETUP+1) clocks.
- R5: After SCL is released, the timer waits 8+F clocks with `scl_in` high. `smp` then pulses, and the high phase runs for (DIV+1)*(H+1) clocks.
- R6: Every clock in which `scl_in` reads low during that wait restarts the wait, which delays `smp` by the stretched clocks.
- R7: A start (`cmd_op`=0) leaves SCL released and runs the release wait. It then waits (DIV+1)*(start setup+1) clocks, pulses `sda_upd`, and finishes after (DIV+1)*(start hold+1) clocks.
- R8: A stop (`cmd_op`=2) runs a low phase as in R2 to R4, then the release wait, then (DIV+1)*(stop setup+1) clocks. `sda_upd` pulses on its last clock.
- R9: A repeated start (`cmd_op`=3) runs a low phase and the release wait, then (DIV+1)*(release+1) clocks, then `sda_upd` and the start hold as in R7.
- R10: `hs_mode` is sampled only when an operation is accepted (1 selects `hs_set`/`hs_div`). Changing it during an operation has no effect on that operation.
- R11: `cmd_ready` is high while idle and on the last clock of each operation. An operation accepted on that last clock starts on the next clock with no gap. Without `cmd_valid` the timer goes idle with SCL released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hs_mode | input | 1 | Selects the high-speed set at acceptance |
| fs_set | input | 7*CNT_W | Fast-speed phase counts |
| fs_div | input | DIV_W | Fast-speed prescaler |
| hs_set | input | 7*CNT_W | High-speed phase counts |
| hs_div | input | DIV_W | High-speed prescaler |
| dat_hold | input | CNT_W | Data hold count, shared |
| flt_cyc | input | FLT_W | Input-filter delay in clocks |
| cmd_valid | input | 1 | Operation request |
| cmd_op | input | 2 | 0 start, 1 bit, 2 stop, 3 repeated start |
| cmd_ready | output | 1 | Operation can be taken this clock |
| scl_in | input | 1 | Sampled SCL level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_upd | output | 1 | Strobe: change SDA now |
| smp | output | 1 | Strobe: sample SDA now |
| busy | output | 1 | Operation in progress |

## Verification
The bench targets these corner cases:
- Setup and hold exactly fill the low count. A design that pads the low phase early would move the release.
- Hold plus setup exceeds the low count. A design that ignores the setup stretch would release SCL early.
- A slave holds SCL low during the release wait, both in a data bit and in a start. A design that starts the high count at release would sample too early.
- The mode input flips in the middle of a high-speed bit. A design that follows the live mode would switch prescaler or counts mid-phase.
- Back-to-back operations across every kind. An off-by-one in the hand-over would add or drop a clock.

// File: rtl/scl_phase_timer.sv
module scl_phase_timer #(
  parameter int CNT_W = 8,
  parameter int DIV_W = 8,
  parameter int FLT_W = 3,
  parameter bit FLT_TWICE = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hs_mode,
  input  logic [7*CNT_W-1:0] fs_set,
  input  logic [DIV_W-1:0]   fs_div,
  input  logic [7*CNT_W-1:0] hs_set,
  input  logic [DIV_W-1:0]   hs_div,
  input  logic [CNT_W-1:0]   dat_hold,
  input  logic [FLT_W-1:0]   flt_cyc,
  input  logic               cmd_valid,
  input  logic [1:0]         cmd_op,
  output logic               cmd_ready,
  input  logic               scl_in,
  output logic               scl_oe,
  output logic               sda_upd,
  output logic               smp,
  output logic               busy
);
  localparam int SEG_W = CNT_W + 1;
  localparam int OVH_W = FLT_W + 5;
  localparam logic [1:0] OP_START = 2'd0;
  localparam logic [1:0] OP_BIT   = 2'd1;
  localparam logic [1:0] OP_STOP  = 2'd2;

  typedef enum logic [2:0] {
    S_IDLE, S_LOW, S_OVH, S_HIGH, S_SR, S_SSU, S_SHD, S_PSU
  } st_t;

  st_t              state, nxt;
  logic [1:0]       op_q;
  logic             sel_q;
  logic [DIV_W-1:0] pre_cnt;
  logic [SEG_W-1:0] seg_cnt, seg_n;
  logic [OVH_W-1:0] ovh_cnt, ovh_len;

  wire [7*CNT_W-1:0] cur   = sel_q ? hs_set : fs_set;
  wire [DIV_W-1:0]   t_div = sel_q ? hs_div : fs_div;
  wire [CNT_W-1:0] t_high  = cur[0*CNT_W +: CNT_W];
  wire [CNT_W-1:0] t_low   = cur[1*CNT_W +: CNT_W];
  wire [CNT_W-1:0] t_dsu   = cur[2*CNT_W +: CNT_W];
  wire [CNT_W-1:0] t_sr    = cur[3*CNT_W +: CNT_W];
  wire [CNT_W-1:0] t_susto = cur[4*CNT_W +: CNT_W];
  wire [CNT_W-1:0] t_hdsta = cur[5*CNT_W +: CNT_W];
  wire [CNT_W-1:0] t_susta = cur[6*CNT_W +: CNT_W];

  wire [SEG_W-1:0] hd_su   = SEG_W'(dat_hold) + SEG_W'(t_dsu);
  wire [SEG_W-1:0] low_end = (hd_su > SEG_W'(t_low)) ? hd_su : SEG_W'(t_low);

  generate
    if (FLT_TWICE) begin : g_flt_dbl
      assign ovh_len = OVH_W'(8) + (OVH_W'(flt_cyc) << 1);
    end else begin : g_flt_one
      assign ovh_len = OVH_W'(8) + OVH_W'(flt_cyc);
    end
  endgenerate

  always_comb begin
    case (state)
      S_LOW:   seg_n = low_end;
      S_HIGH:  seg_n = SEG_W'(t_high);
      S_SR:    seg_n = SEG_W'(t_sr);
      S_SSU:   seg_n = SEG_W'(t_susta);
      S_SHD:   seg_n = SEG_W'(t_hdsta);
      S_PSU:   seg_n = SEG_W'(t_susto);
      default: seg_n = '0;
    endcase
  end

  wire pre_last = (pre_cnt == t_div);
  wire seg_end  = pre_last && (seg_cnt == seg_n);
  wire ovh_end  = scl_in && (ovh_cnt == ovh_len - OVH_W'(1));
  wire seg_top  = (seg_cnt == '0) && (pre_cnt == '0);
  wire fin      = seg_end && (state == S_HIGH || state == S_SHD || state == S_PSU);
  wire take     = cmd_valid && cmd_ready;

  assign cmd_ready = (state == S_IDLE) || fin;
  assign busy      = (state != S_IDLE);
  assign scl_oe    = (state == S_LOW);
  assign smp       = (state == S_HIGH) && seg_top;
  assign sda_upd   = ((state == S_LOW) && (seg_cnt == SEG_W'(dat_hold)) && (pre_cnt == '0))
                   || ((state == S_SHD) && seg_top)
                   || ((state == S_PSU) && seg_end);

  always_comb begin
    nxt = state;
    case (state)
      S_LOW: if (seg_end) nxt = S_OVH;
      S_OVH:
        if (ovh_end) begin
          case (op_q)
            OP_START: nxt = S_SSU;
            OP_BIT:   nxt = S_HIGH;
            OP_STOP:  nxt = S_PSU;
            default:  nxt = S_SR;
          endcase
        end
      S_SSU, S_SR: if (seg_end) nxt = S_SHD;
      S_HIGH, S_SHD, S_PSU: if (seg_end) nxt = S_IDLE;
      default: nxt = state;
    endcase
    if (take) nxt = (cmd_op == OP_START) ? S_OVH : S_LOW;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      op_q    <= OP_BIT;
      sel_q   <= 1'b0;
      pre_cnt <= '0;
      seg_cnt <= '0;
      ovh_cnt <= '0;
    end else begin
      state <= nxt;
      if (take) begin
        op_q  <= cmd_op;
        sel_q <= hs_mode;
      end
      if (nxt != state) begin
        pre_cnt <= '0;
        seg_cnt <= '0;
        ovh_cnt <= '0;
      end else if (state == S_OVH) begin
        ovh_cnt <= scl_in ? ovh_cnt + OVH_W'(1) : '0;
      end else if (state != S_IDLE) begin
        if (pre_last) begin
          pre_cnt <= '0;
          seg_cnt <= seg_cnt + SEG_W'(1);
        end else begin
          pre_cnt <= pre_cnt + DIV_W'(1);
        end
      end
    end
  end
endmodule

module scl_phase_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_valid,
  input logic cmd_ready,
  input logic scl_in,
  input logic scl_oe,
  input logic smp,
  input logic busy
);
  assert_low_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_oe) |-> $past(cmd_valid && cmd_ready));
  assert_release_in_op_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_oe) |-> busy);
  assert_sample_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
    smp |-> !scl_oe);
  assert_stretch_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !scl_oe && !scl_in) |=> !smp);
  assert_accept_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> busy);
endmodule

bind scl_phase_timer scl_phase_timer_chk i_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .scl_in(scl_in), .scl_oe(scl_oe), .smp(smp), .busy(busy)
);

// File: tb/test_scl_phase_timer.sv
`timescale 1ns/1ps
module test_scl_phase_timer;
  typedef struct {int d, l, h, su, susta, hdsta, susto, sr;} pset_t;
  typedef struct {int kind; int t; string req;} ev_t;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, hs_mode, cmd_valid, cmd_ready, scl_in, scl_oe, sda_upd, smp, busy;
  logic [55:0] fs_set, hs_set;
  logic [7:0] fs_div, hs_div, dat_hold;
  logic [2:0] flt_cyc;
  logic [1:0] cmd_op;
  logic hold_low = 1'b0;

  assign scl_in = !scl_oe && !hold_low;

  scl_phase_timer i_scl_phase_timer (
    .clk(clk), .rst_n(rst_n), .hs_mode(hs_mode), .fs_set(fs_set), .fs_div(fs_div),
    .hs_set(hs_set), .hs_div(hs_div), .dat_hold(dat_hold), .flt_cyc(flt_cyc),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_ready(cmd_ready), .scl_in(scl_in),
    .scl_oe(scl_oe), .sda_upd(sda_upd), .smp(smp), .busy(busy)
  );

  int cyc = 0, n_cmp = 0, n_bad = 0, st_from = -1, st_to = -1, hd = 0, ovh = 0;
  bit finished = 0;
  pset_t fs_p, hs_p;
  ev_t expq[$];
  logic oe_d = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) hold_low = (cyc >= st_from) && (cyc < st_to);

  function automatic string kname(int k);
    case (k)
      0: return "scl_low"; 1: return "scl_release"; 2: return "sda_upd";
      3: return "smp"; default: return "done";
    endcase
  endfunction

  function automatic logic [55:0] pk(pset_t p);
    return {8'(p.susta), 8'(p.hdsta), 8'(p.susto), 8'(p.sr), 8'(p.su), 8'(p.l), 8'(p.h)};
  endfunction

  task automatic apply();
    fs_set = pk(fs_p); fs_div = 8'(fs_p.d);
    hs_set = pk(hs_p); hs_div = 8'(hs_p.d);
    dat_hold = 8'(hd); ovh = 8 + int'(flt_cyc);
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0d, expected %0d", req, act, exp);
    end
  endtask

  task automatic push(int k, int t, string r);
    ev_t e;
    e.kind = k; e.t = t; e.req = r;
    expq.push_back(e);
  endtask

  task automatic see(int k);
    ev_t e;
    n_cmp++;
    if (expq.size() == 0) begin
      n_bad++;
      $display("FAIL R11: got %s at t=%0d, expected no event", kname(k), cyc);
    end else begin
      e = expq.pop_front();
      if (e.kind != k || e.t != cyc) begin
        n_bad++;
        $display("FAIL %s: got %s at t=%0d, expected %s at t=%0d",
                 e.req, kname(k), cyc, kname(e.kind), e.t);
      end
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (scl_oe && !oe_d) see(0);
      if (!scl_oe && oe_d) see(1);
      if (sda_upd) see(2);
      if (smp) see(3);
      if (cmd_ready && busy) see(4);
    end
    oe_d = scl_oe;
  end

  // op: 0 start, 1 bit, 2 stop, 3 repeated start; k = stretch clocks
  task automatic do_cmd(int op, int k, bit flip);
    pset_t p;
    int s, dv, e, tr, o, x, done;
    string tg;
    cmd_op = 2'(op); cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    p = hs_mode ? hs_p : fs_p;
    dv = p.d + 1;
    s = cyc + 1;
    tg = (op == 0) ? "R7" : (op == 2) ? "R8" : (op == 3) ? "R9" : "R2";
    if (flip) tg = "R10";
    if (op == 0) begin
      o = s;
    end else begin
      e = (hd + p.su > p.l) ? hd + p.su : p.l;
      push(0, s, tg);
      push(2, s + hd * dv, (op == 1 && !flip) ? "R3" : tg);
      tr = s + (e + 1) * dv;
      push(1, tr, (op == 1 && !flip && e > p.l) ? "R4" : tg);
      o = tr;
    end
    if (k > 0) begin st_from = o; st_to = o + k; end
    x = o + k + ovh;
    case (op)
      0: begin
        x = x + (p.susta + 1) * dv; push(2, x, tg);
        done = x + (p.hdsta + 1) * dv - 1;
      end
      1: begin
        push(3, x, flip ? tg : (k > 0) ? "R6" : "R5");
        done = x + (p.h + 1) * dv - 1;
      end
      2: begin
        done = x + (p.susto + 1) * dv - 1; push(2, done, tg);
      end
      default: begin
        x = x + (p.sr + 1) * dv; push(2, x, tg);
        done = x + (p.hdsta + 1) * dv - 1;
      end
    endcase
    push(4, done, (op == 1 && !flip) ? "R11" : tg);
    @(negedge clk);
    if (flip) begin
      hs_mode = !hs_mode;
      repeat (3) @(negedge clk);
      hs_mode = !hs_mode;
    end
  endtask

  task automatic drain();
    cmd_valid = 1'b0;
    while (expq.size() > 0) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(cmd_ready == 1'b1, "R11", int'(cmd_ready), 1);
    chk(busy == 1'b0 && scl_oe == 1'b0, "R11", int'({busy, scl_oe}), 0);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R11: watchdog expired, got hang, expected completion");
    report();
  end

  initial begin
    rst_n = 1'b0; hs_mode = 1'b0; cmd_valid = 1'b0; cmd_op = 2'd0;
    fs_p = '{d: 2, l: 6, h: 5, su: 1, susta: 4, hdsta: 3, susto: 5, sr: 7};
    hs_p = '{d: 0, l: 3, h: 2, su: 1, susta: 2, hdsta: 1, susto: 2, sr: 3};
    hd = 2; flt_cyc = 3'd3;
    apply();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(scl_oe == 1'b0, "R1", int'(scl_oe), 0);
    chk(sda_upd == 1'b0 && smp == 1'b0, "R1", int'({sda_upd, smp}), 0);
    chk(cmd_ready == 1'b1, "R1", int'(cmd_ready), 1);
    chk(busy == 1'b0, "R1", int'(busy), 0);

    do_cmd(0, 0, 0);
    do_cmd(1, 0, 0);
    do_cmd(1, 5, 0);
    do_cmd(3, 0, 0);
    do_cmd(1, 0, 0);
    do_cmd(2, 0, 0);
    drain();

    hs_mode = 1'b1;
    do_cmd(0, 2, 0);
    do_cmd(1, 0, 1);
    do_cmd(1, 0, 0);
    do_cmd(2, 0, 0);
    drain();

    hd = 5; flt_cyc = 3'd0;
    apply();
    do_cmd(1, 0, 0);
    do_cmd(2, 0, 0);
    drain();

    hs_mode = 1'b0;
    do_cmd(1, 3, 0);
    do_cmd(3, 0, 0);
    do_cmd(2, 0, 0);
    drain();

    chk(expq.size() == 0, "R11", expq.size(), 0);
    report();
  end
endmodule